// File: doc/BRIEF.md
# Serial Link Stream Gating Controller

This block sits between a board's high-speed serial link and the logic around it. Four word streams pass through it, each with a ready/valid handshake and an end-of-packet flag:

- stream 0 carries link traffic to the UDP offload engine;
- stream 1 carries detector data from the UDP sender to the link;
- stream 2 carries link traffic to the Ethernet MAC and processor side;
- stream 3 carries MAC and processor traffic to the link.

A 16-bit control word opens or closes each stream. A closed stream does not stall its source. It accepts every word offered and discards it, and its sink sees no valid data.

Each stream has a small state machine with three states:

- `ST_IDLE`: between packets.
- `ST_PASS`: inside a forwarded packet.
- `ST_DROP`: inside a discarded packet.

The machine has these transitions:

- `IDLE->PASS`: a non-final word is accepted while the stream is open.
- `IDLE->DROP`: a non-final word is accepted while the stream is closed.
- `PASS->IDLE` and `DROP->IDLE`: the final word of the packet is accepted.

A single-word packet leaves the machine in `ST_IDLE`. Both the open/closed decision and the test-pattern decision are taken in `ST_IDLE`. They stay latched until the packet ends, so a packet is never cut short.

On the two outgoing streams (1 and 3), the payload can be replaced by a counting test pattern. The same control word also sets two flow-control outputs: a local transmit stop and a stop request sent to the far end. Each can follow an almost-full input under an enable bit, or be forced on by hand.

Top module: `link_stream_gate`

## Requirements
- R1: Control bit 0 opens stream 0, bit 1 opens stream 1, bit 2 opens stream 2 and bit 3 opens stream 3. While a stream is open, its sink valid equals the source valid, and data and last are forwarded unchanged. The source ready equals the sink ready.
- R2: While a stream is closed, its sink valid is 0 and its source ready is 1, so offered words are consumed and discarded.
- R3: Control bit 12 closes stream 2 and bit 13 closes stream 3, whatever the state of bits 2 and 3.
- R4: Open/closed and pattern choices are sampled only between packets, that is, on the first word of a packet. Control changes made while a packet is in progress take effect only after its final word (last = 1) is accepted.
- R5: Control bit 8 replaces stream 1 data with the test pattern, and bit 9 does the same for stream 3. The pattern starts at 0x11111111 and advances by 0x11111111 on each word accepted by the sink. After 0xFFFFFFFF it returns to 0x11111111. Each stream keeps its own position across packets. The last flag is still forwarded.
- R6: The local transmit stop is registered. One cycle after the inputs, it equals (bit 4 AND downstream almost-full) OR bit 5.
- R7: The remote stop request is registered. One cycle after the inputs, it equals (bit 6 AND receive almost-full) OR bit 7.
- R8: Control bits 10, 11, 14 and 15 have no effect on any output.
- R9: After reset, both flow-control outputs are 0, every stream is between packets, and each pattern position is 0x11111111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 16 | Control word (bit meanings in R1–R8) |
| src_valid | input | 4 | Per-stream source valid |
| src_data | input | 4×DATA_W | Per-stream source data |
| src_last | input | 4 | Per-stream end of packet |
| src_ready | output | 4 | Per-stream ready toward the source |
| snk_valid | output | 4 | Per-stream valid toward the sink |
| snk_data | output | 4×DATA_W | Per-stream data toward the sink |
| snk_last | output | 4 | Per-stream end of packet toward the sink |
| snk_ready | input | 4 | Per-stream ready from the sink |
| ds_almost_full | input | 1 | Downstream FIFO almost full |
| rx_almost_full | input | 1 | Receive FIFO almost full |
| local_tx_stop | output | 1 | Local transmit-stop signal |
| remote_stop_req | output | 1 | Request for the far end to stop sending |

## Verification
The hardest case to reach is a control change that arrives while a packet is in progress, in `ST_PASS` or `ST_DROP`. This is where the latched decision must win over the new control word. Directed sequences open a stream, start a multi-word packet, and close the stream before the final word (and the reverse). Long random runs then change the control word at random times against sparse last flags, so that many packets straddle a control change. The pattern wrap is reached by a directed run of more than fifteen accepted words on stream 1.

// File: rtl/link_gate_pkg.sv
`timescale 1ns/1ps
package link_gate_pkg;
    localparam int NUM_STREAMS = 4;
    localparam int CTRL_W      = 16;

    // control bit positions
    localparam int B_LINK_TO_UDP  = 0;
    localparam int B_UDP_TO_LINK  = 1;
    localparam int B_LINK_TO_ETH  = 2;
    localparam int B_ETH_TO_LINK  = 3;
    localparam int B_LSTOP_EN     = 4;
    localparam int B_LSTOP_FORCE  = 5;
    localparam int B_RSTOP_EN     = 6;
    localparam int B_RSTOP_FORCE  = 7;
    localparam int B_PAT_UDP      = 8;
    localparam int B_PAT_ETH      = 9;
    localparam int B_LINK_ETH_OFF = 12;
    localparam int B_ETH_LINK_OFF = 13;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_DROP = 2'd2
    } gate_state_e;

    function automatic logic stream_open(input logic [CTRL_W-1:0] c, input int idx);
        case (idx)
            0:       return c[B_LINK_TO_UDP];
            1:       return c[B_UDP_TO_LINK];
            2:       return c[B_LINK_TO_ETH] & ~c[B_LINK_ETH_OFF];
            default: return c[B_ETH_TO_LINK] & ~c[B_ETH_LINK_OFF];
        endcase
    endfunction

    function automatic logic stream_pattern(input logic [CTRL_W-1:0] c, input int idx);
        case (idx)
            1:       return c[B_PAT_UDP];
            3:       return c[B_PAT_ETH];
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/lg_pattern_gen.sv
`timescale 1ns/1ps
module lg_pattern_gen #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [DATA_W-1:0] word
);
    localparam logic [DATA_W-1:0] STEP = {(DATA_W/4){4'h1}};
    localparam logic [DATA_W-1:0] TOP  = {DATA_W{1'b1}};

    logic [DATA_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= STEP;
        else if (adv)
            cnt_q <= (cnt_q == TOP) ? STEP : cnt_q + STEP;
    end

    assign word = cnt_q;

    // R5
    pat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(adv) && $past(cnt_q) != TOP) |-> (cnt_q == $past(cnt_q) + STEP));

    // R5
    pat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(adv) && $past(cnt_q) == TOP) |-> (cnt_q == STEP));
endmodule

// File: rtl/lg_stream_gate.sv
`timescale 1ns/1ps
module lg_stream_gate
    import link_gate_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_req,
    input  logic              pat_req,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    input  logic              m_ready
);
    gate_state_e       state_q, state_d;
    logic              pat_q;
    logic              open_eff, pat_eff, accept, adv;
    logic [DATA_W-1:0] pat_word;

    always_comb begin
        open_eff = 1'b0;
        pat_eff  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin open_eff = open_req; pat_eff = pat_req; end
            ST_PASS: begin open_eff = 1'b1;     pat_eff = pat_q;   end
            ST_DROP: begin open_eff = 1'b0;     pat_eff = 1'b0;    end
            default: begin open_eff = 1'b0;     pat_eff = 1'b0;    end
        endcase
    end

    assign accept = s_valid && s_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !s_last) state_d = open_eff ? ST_PASS : ST_DROP;
            ST_PASS: if (accept && s_last)  state_d = ST_IDLE;
            ST_DROP: if (accept && s_last)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pat_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_PASS)
                pat_q <= pat_req;
        end
    end

    always_comb begin
        m_valid = open_eff && s_valid;
        s_ready = open_eff ? m_ready : 1'b1;
        m_data  = pat_eff ? pat_word : s_data;
        m_last  = s_last;
        adv     = open_eff && pat_eff && s_valid && m_ready;
    end

    lg_pattern_gen #(.DATA_W(DATA_W)) u_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .word  (pat_word)
    );

    // R4
    mid_pkt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS && s_valid) |-> (m_valid && s_ready == m_ready));

    // R2
    drop_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |-> (s_ready && !m_valid));

    // R4
    hold_until_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !(accept && s_last)) |=> (state_q == $past(state_q)));
endmodule

// File: rtl/lg_flow_ctrl.sv
`timescale 1ns/1ps
module lg_flow_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic lstop_en,
    input  logic lstop_force,
    input  logic rstop_en,
    input  logic rstop_force,
    input  logic ds_afull,
    input  logic rx_afull,
    output logic local_stop,
    output logic remote_stop
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            local_stop  <= 1'b0;
            remote_stop <= 1'b0;
        end else begin
            local_stop  <= (lstop_en & ds_afull) | lstop_force;
            remote_stop <= (rstop_en & rx_afull) | rstop_force;
        end
    end

    // R6
    local_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lstop_force)) |-> local_stop);

    // R7
    remote_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rstop_force)) |-> remote_stop);

    // R6
    local_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(lstop_force) && !$past(ds_afull)) |-> !local_stop);
endmodule

// File: rtl/link_stream_gate.sv
`timescale 1ns/1ps
module link_stream_gate
    import link_gate_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [CTRL_W-1:0]                   ctrl_word,
    input  logic [NUM_STREAMS-1:0]              src_valid,
    input  logic [NUM_STREAMS-1:0][DATA_W-1:0]  src_data,
    input  logic [NUM_STREAMS-1:0]              src_last,
    output logic [NUM_STREAMS-1:0]              src_ready,
    output logic [NUM_STREAMS-1:0]              snk_valid,
    output logic [NUM_STREAMS-1:0][DATA_W-1:0]  snk_data,
    output logic [NUM_STREAMS-1:0]              snk_last,
    input  logic [NUM_STREAMS-1:0]              snk_ready,
    input  logic                                ds_almost_full,
    input  logic                                rx_almost_full,
    output logic                                local_tx_stop,
    output logic                                remote_stop_req
);
    // R8: reserved control bits reach no logic
    logic rsvd_unused;
    assign rsvd_unused = ^{ctrl_word[15:14], ctrl_word[11:10]};

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
        logic open_req, pat_req;
        assign open_req = stream_open(ctrl_word, g);
        assign pat_req  = stream_pattern(ctrl_word, g);

        lg_stream_gate #(.DATA_W(DATA_W)) u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_req (open_req),
            .pat_req  (pat_req),
            .s_valid  (src_valid[g]),
            .s_data   (src_data[g]),
            .s_last   (src_last[g]),
            .s_ready  (src_ready[g]),
            .m_valid  (snk_valid[g]),
            .m_data   (snk_data[g]),
            .m_last   (snk_last[g]),
            .m_ready  (snk_ready[g])
        );
    end

    lg_flow_ctrl u_flow (
        .clk         (clk),
        .rst_n       (rst_n),
        .lstop_en    (ctrl_word[B_LSTOP_EN]),
        .lstop_force (ctrl_word[B_LSTOP_FORCE]),
        .rstop_en    (ctrl_word[B_RSTOP_EN]),
        .rstop_force (ctrl_word[B_RSTOP_FORCE]),
        .ds_afull    (ds_almost_full),
        .rx_afull    (rx_almost_full),
        .local_stop  (local_tx_stop),
        .remote_stop (remote_stop_req)
    );
endmodule

// File: tb/test_link_stream_gate.sv
`timescale 1ns/1ps
module test_link_stream_gate;
    localparam int DW = 32;
    localparam int NS = 4;
    localparam logic [DW-1:0] STEP = 32'h11111111;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [15:0]           ctrl = '0;
    logic [NS-1:0]         sv = '0, sl = '0, mr = '0;
    logic [NS-1:0][DW-1:0] sd = '0;
    logic [NS-1:0]         sr, mv, ml;
    logic [NS-1:0][DW-1:0] md;
    logic                  dafull = 1'b0, rafull = 1'b0;
    logic                  lstop, rstop;

    int checks = 0;
    int fails  = 0;

    bit            in_pkt [NS];
    bit            pen    [NS];
    bit            ppat   [NS];
    logic [DW-1:0] pcnt   [NS];
    bit            exp_ls, exp_rs;

    always #10 clk = ~clk;

    link_stream_gate #(.DATA_W(DW)) i_link_stream_gate (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl),
        .src_valid(sv), .src_data(sd), .src_last(sl), .src_ready(sr),
        .snk_valid(mv), .snk_data(md), .snk_last(ml), .snk_ready(mr),
        .ds_almost_full(dafull), .rx_almost_full(rafull),
        .local_tx_stop(lstop), .remote_stop_req(rstop)
    );

    function automatic bit f_open(input logic [15:0] c, input int i);
        case (i)
            0: return c[0];
            1: return c[1];
            2: return c[2] & ~c[12];
            default: return c[3] & ~c[13];
        endcase
    endfunction

    function automatic bit f_pat(input logic [15:0] c, input int i);
        if (i == 1) return c[8];
        if (i == 3) return c[9];
        return 1'b0;
    endfunction

    function automatic logic [DW-1:0] f_next(input logic [DW-1:0] v);
        return (v == 32'hFFFFFFFF) ? STEP : v + STEP;
    endfunction

    task automatic chk(input string tag, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    // inputs are already driven after a negedge; check, advance model, wait next negedge
    task automatic cycle(input string tag);
        #2;
        for (int i = 0; i < NS; i++) begin
            bit en, pat, esr, hs;
            en  = in_pkt[i] ? pen[i]  : f_open(ctrl, i);
            pat = in_pkt[i] ? ppat[i] : f_pat(ctrl, i);
            esr = en ? mr[i] : 1'b1;
            chk(tag, $sformatf("stream%0d snk_valid", i), DW'(mv[i]), DW'(en & sv[i]));
            chk(tag, $sformatf("stream%0d src_ready", i), DW'(sr[i]), DW'(esr));
            if (en && sv[i]) begin
                chk(tag, $sformatf("stream%0d snk_data", i), md[i], pat ? pcnt[i] : sd[i]);
                chk(tag, $sformatf("stream%0d snk_last", i), DW'(ml[i]), DW'(sl[i]));
            end
            hs = sv[i] & esr;
            if (hs && en && pat) pcnt[i] = f_next(pcnt[i]);
            if (hs) begin
                if (!in_pkt[i] && !sl[i]) begin
                    in_pkt[i] = 1'b1; pen[i] = en; ppat[i] = pat;
                end else if (in_pkt[i] && sl[i]) begin
                    in_pkt[i] = 1'b0;
                end
            end
        end
        chk(tag, "local_tx_stop (R6)", DW'(lstop), DW'(exp_ls));
        chk(tag, "remote_stop_req (R7)", DW'(rstop), DW'(exp_rs));
        exp_ls = (ctrl[4] & dafull) | ctrl[5];
        exp_rs = (ctrl[6] & rafull) | ctrl[7];
        @(negedge clk);
    endtask

    task automatic idle_all();
        sv = '0; sl = '0; mr = '0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NS; i++) begin
            in_pkt[i] = 0; pen[i] = 0; ppat[i] = 0; pcnt[i] = STEP;
        end
        exp_ls = 0; exp_rs = 0;
        ctrl = 16'h00A0; dafull = 1; rafull = 1;
        repeat (3) @(negedge clk);
        // R9: outputs held low under reset even with force bits set
        chk("R9", "local_tx_stop in reset", DW'(lstop), '0);
        chk("R9", "remote_stop_req in reset", DW'(rstop), '0);
        ctrl = '0; dafull = 0; rafull = 0;
        rst_n = 1'b1;
        @(negedge clk);
        cycle("R9");

        // R5 / R9: pattern on stream 1 from reset value, through the wrap
        ctrl = 16'h0102;
        for (int k = 0; k < 20; k++) begin
            idle_all();
            sv[1] = 1; mr[1] = 1; sd[1] = $urandom; sl[1] = (k % 5 == 4);
            cycle("R5");
        end
        // R5: back-pressured words do not advance the pattern
        for (int k = 0; k < 6; k++) begin
            idle_all();
            sv[1] = 1; mr[1] = k[0]; sd[1] = $urandom; sl[1] = 0;
            cycle("R5");
        end
        idle_all(); sv[1] = 1; mr[1] = 1; sl[1] = 1; cycle("R5");

        // R4: close stream 0 in the middle of a packet
        ctrl = 16'h0001;
        idle_all(); sv[0] = 1; mr[0] = 1; sd[0] = 32'hA0A0_0001; cycle("R4");
        ctrl = 16'h0000;
        idle_all(); sv[0] = 1; mr[0] = 1; sd[0] = 32'hA0A0_0002; cycle("R4");
        idle_all(); sv[0] = 1; mr[0] = 0; sd[0] = 32'hA0A0_0003; cycle("R4");
        idle_all(); sv[0] = 1; mr[0] = 1; sl[0] = 1; sd[0] = 32'hA0A0_0004; cycle("R4");
        idle_all(); sv[0] = 1; mr[0] = 0; sd[0] = 32'hA0A0_0005; cycle("R2");
        // R4: open stream 0 while a dropped packet is in progress
        ctrl = 16'h0001;
        idle_all(); sv[0] = 1; mr[0] = 1; sd[0] = 32'hA0A0_0006; cycle("R4");
        idle_all(); sv[0] = 1; mr[0] = 1; sl[0] = 1; sd[0] = 32'hA0A0_0007; cycle("R4");
        idle_all(); sv[0] = 1; mr[0] = 1; sl[0] = 1; sd[0] = 32'hA0A0_0008; cycle("R1");

        // R3: overrides close the Ethernet streams
        ctrl = 16'h300C;
        for (int k = 0; k < 4; k++) begin
            idle_all(); sv[2] = 1; sv[3] = 1; sl = 4'hF; sd[2] = $urandom; sd[3] = $urandom;
            cycle("R3");
        end
        ctrl = 16'h000C;
        idle_all(); sv = 4'hC; mr = 4'hC; sl = 4'hC; sd[2] = $urandom; sd[3] = $urandom; cycle("R1");

        // R6 / R7: all combinations of enable, force and almost-full
        for (int k = 0; k < 16; k++) begin
            idle_all();
            ctrl = {8'h00, k[1], k[0], k[1], k[0], 4'h0};
            dafull = k[2]; rafull = k[3];
            cycle("R6");
            cycle("R7");
        end
        dafull = 0; rafull = 0;

        // R8: reserved bits alone, then on top of random settings
        ctrl = 16'hCC00;
        for (int k = 0; k < 8; k++) begin
            sv = 4'($urandom); sl = 4'($urandom); mr = 4'($urandom);
            for (int i = 0; i < NS; i++) sd[i] = $urandom;
            dafull = 1; rafull = 1;
            cycle("R8");
        end
        for (int k = 0; k < 400; k++) begin
            if (k % 16 == 0) ctrl = 16'($urandom) | 16'hCC00;
            sv = 4'($urandom); mr = 4'($urandom) | 4'($urandom);
            sl = 4'($urandom) & 4'($urandom);
            for (int i = 0; i < NS; i++) sd[i] = $urandom;
            dafull = $urandom; rafull = $urandom;
            cycle("R8");
        end

        // R1: constrained random traffic with control changes mid-packet
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(15) == 0) ctrl = 16'($urandom);
            sv = 4'($urandom); mr = 4'($urandom) | 4'($urandom);
            sl = 4'($urandom) & 4'($urandom);
            for (int i = 0; i < NS; i++) sd[i] = $urandom;
            dafull = $urandom; rafull = $urandom;
            cycle("R1");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule